// File: doc/BRIEF.md
# 1-Wire Bus Master Sequencer

This block is a self-timed master for a 1-Wire bus. A host hands it one command with its operand. The block then runs the timing-critical bus activity by itself, with no further help from the host. It drives an open-drain pull-down output and samples the bus level. When the activity ends, it leaves its results in status flags and in a received-byte register. The supported operations are:

- a bus reset with presence detection,
- writing a byte,
- reading a byte,
- a single-bit exchange,
- the three-slot search step used to enumerate device identifiers.

All bus timing is counted in time units. One unit is `TICK_DIV` system clocks, so the default setting of 200 at a 200 MHz clock gives one microsecond per unit. Every slot can run at normal speed or at overdrive speed. A presence-masking option can also be chosen. Both of these settings are taken from configuration inputs at the moment a command is accepted.

Top module: `owm_seq`

## Requirements
- R1: `cmd_op` selects the operation: 0 is a bus reset, 1 writes a byte, 2 reads a byte, 3 exchanges a single bit, and 4 runs a search step. Codes 5 to 7 are ignored: `busy` stays low and the bus is not touched.
- R2: A command is accepted only when `cmd_valid` is high and the block is idle. `busy` rises on the next clock and stays high until the operation ends. At that point `st_done` is set. A command presented while `busy` is high has no effect.
- R3: A reset holds the bus low for 480 units at normal speed and 48 units at overdrive. `st_presence` is set when the bus reads low at the presence sample point, about 70 units (normal) or 8 units (overdrive) after release.
- R4: `st_short` is set when the bus is low at the presence sample point and is still low at the end of the recovery window. That window ends 480 units (normal) or 48 units (overdrive) after release. A short always comes with `st_presence` set.
- R5: If presence masking is selected when a reset is accepted, `st_presence` reads 1 whether or not any device answered.
- R6: A byte write sends bits least-significant first, one slot per bit. The slot lasts 70 units at normal speed and 10 units at overdrive. For a 1 the bus is pulled low for 6 units (normal) or 1 unit (overdrive). For a 0 it is pulled low for 60 units (normal) or 8 units (overdrive).
- R7: A byte read runs eight read slots and assembles the bits least-significant first into `rd_data`. Each read slot pulls the bus low as a write-1 slot does. The bus is sampled 15 units (normal) or 2 units (overdrive) after the slot starts.
- R8: A single-bit exchange runs one slot that writes `cmd_bit`. The bus level sampled in that slot is reported in `st_bit`.
- R9: A search step reads an identifier bit into `st_bit`, then reads its complement into `st_bit2`, then writes a direction bit, which is reported in `st_dir`. The direction is `cmd_bit` when both bits read 0; otherwise it is the identifier bit. When both bits read 1, `st_err` is also set.
- R10: Accepting a command clears `st_done` and all result flags. `rd_data` is kept until the next byte read completes. The speed and masking settings are captured at acceptance.
- R11: After reset, `busy`, `drive_low`, all status flags and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code |
| cmd_data | input | DATA_W | Byte to write |
| cmd_bit | input | 1 | Bit value for single-bit exchange; preferred direction for search step |
| cfg_overdrive | input | 1 | 1 selects overdrive slot timing |
| cfg_mask_presence | input | 1 | 1 masks the presence result of a reset |
| line_in | input | 1 | Sampled bus level |
| drive_low | output | 1 | 1 pulls the bus low (open-drain enable) |
| busy | output | 1 | Operation in progress |
| st_done | output | 1 | Last accepted operation completed |
| st_presence | output | 1 | Presence seen in last reset |
| st_short | output | 1 | Bus short seen in last reset |
| st_bit | output | 1 | Sampled bit (single-bit exchange) or identifier bit (search step) |
| st_bit2 | output | 1 | Complement bit of a search step |
| st_dir | output | 1 | Direction written by a search step |
| st_err | output | 1 | Search step read 1 for both the identifier bit and its complement |
| rd_data | output | DATA_W | Last byte read |

## Verification
The sequencer has these states: `ST_IDLE`, `ST_RESET`, `ST_WRITE`, `ST_READ`, `ST_BIT`, `ST_TRIP_ID`, `ST_TRIP_CMP` and `ST_TRIP_WR`. Each active state returns to `ST_IDLE` after its last slot. The search states run in order ID, CMP, WR.

A wrong state or a wrong bit counter shows up at the ports within one slot. Depending on the fault, the bus sees a low pulse that is missing, extra or of the wrong width, or `busy` falls too early or too late. A wrong sample point or a wrong direction decision shows up in the flags, or in the bit the bench's device model records in the third slot, by the time `busy` falls.

The bench models a bus device. This device measures each pulse the master drives, answers reads and resets, and logs the bits it hears. Byte values are swept across the full range.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [2:0] {
        OP_RESET   = 3'd0,
        OP_WRBYTE  = 3'd1,
        OP_RDBYTE  = 3'd2,
        OP_BIT     = 3'd3,
        OP_TRIPLET = 3'd4
    } owm_op_e;

    localparam int TIME_W = 10;

    // Slot timing in time units: low length for a 1, for a 0,
    // sample point and total slot length.
    typedef struct packed {
        logic [TIME_W-1:0] low_one;
        logic [TIME_W-1:0] low_zero;
        logic [TIME_W-1:0] sample;
        logic [TIME_W-1:0] total;
    } slot_t;

    function automatic slot_t slot_times(input logic is_rst, input logic od);
        slot_t t;
        unique case ({is_rst, od})
            2'b10: begin
                t.low_one  = TIME_W'(480);
                t.low_zero = TIME_W'(480);
                t.sample   = TIME_W'(550);
                t.total    = TIME_W'(960);
            end
            2'b11: begin
                t.low_one  = TIME_W'(48);
                t.low_zero = TIME_W'(48);
                t.sample   = TIME_W'(56);
                t.total    = TIME_W'(96);
            end
            2'b00: begin
                t.low_one  = TIME_W'(6);
                t.low_zero = TIME_W'(60);
                t.sample   = TIME_W'(15);
                t.total    = TIME_W'(70);
            end
            default: begin
                t.low_one  = TIME_W'(1);
                t.low_zero = TIME_W'(8);
                t.sample   = TIME_W'(2);
                t.total    = TIME_W'(10);
            end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
    parameter int DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || cnt == CW'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == CW'(DIV - 1)) && !clear;
endmodule

// File: rtl/owm_slot.sv
module owm_slot
    import owm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_rst,
    input  logic bit_val,
    input  logic od,
    input  logic tick,
    input  logic line_in,
    output logic drive_low,
    output logic done,
    output logic samp_bit,
    output logic end_bit
);
    logic              active;
    logic              r_rst, r_bit, r_od;
    logic [TIME_W-1:0] cnt;
    slot_t             tm;
    logic [TIME_W-1:0] low_len;

    assign tm      = slot_times(r_rst, r_od);
    assign low_len = r_bit ? tm.low_one : tm.low_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active   <= 1'b0;
            cnt      <= '0;
            r_rst    <= 1'b0;
            r_bit    <= 1'b1;
            r_od     <= 1'b0;
            done     <= 1'b0;
            samp_bit <= 1'b1;
            end_bit  <= 1'b1;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                cnt    <= '0;
                r_rst  <= is_rst;
                r_bit  <= bit_val;
                r_od   <= od;
            end else if (active && tick) begin
                if (cnt == tm.sample) samp_bit <= line_in;
                if (cnt == tm.total - 1'b1) begin
                    active  <= 1'b0;
                    done    <= 1'b1;
                    end_bit <= line_in;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign drive_low = active && (cnt < low_len);
endmodule

// File: rtl/owm_seq.sv
module owm_seq
    import owm_pkg::*;
#(
    parameter int TICK_DIV = 200,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_bit,
    input  logic              cfg_overdrive,
    input  logic              cfg_mask_presence,
    input  logic              line_in,
    output logic              drive_low,
    output logic              busy,
    output logic              st_done,
    output logic              st_presence,
    output logic              st_short,
    output logic              st_bit,
    output logic              st_bit2,
    output logic              st_dir,
    output logic              st_err,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RESET, ST_WRITE, ST_READ,
        ST_BIT, ST_TRIP_ID, ST_TRIP_CMP, ST_TRIP_WR
    } state_e;

    state_e            state, state_nx;
    logic              launch, tick, sdone, samp, endb;
    logic              cur_bit, od_q, mask_q, dir_q;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              last_bit, acc, trip_dir;

    assign acc      = (state == ST_IDLE) && cmd_valid && (cmd_op <= 3'd4);
    assign last_bit = (bitcnt == CNT_W'(DATA_W - 1));
    assign trip_dir = (!st_bit && !samp) ? dir_q : st_bit;
    assign busy     = (state != ST_IDLE);

    owm_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .tick  (tick)
    );

    owm_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (launch),
        .is_rst    (state == ST_RESET),
        .bit_val   (cur_bit),
        .od        (od_q),
        .tick      (tick),
        .line_in   (line_in),
        .drive_low (drive_low),
        .done      (sdone),
        .samp_bit  (samp),
        .end_bit   (endb)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (acc) begin
                    case (owm_op_e'(cmd_op))
                        OP_RESET:   state_nx = ST_RESET;
                        OP_WRBYTE:  state_nx = ST_WRITE;
                        OP_RDBYTE:  state_nx = ST_READ;
                        OP_BIT:     state_nx = ST_BIT;
                        OP_TRIPLET: state_nx = ST_TRIP_ID;
                        default:    state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_RESET, ST_BIT, ST_TRIP_WR: if (sdone) state_nx = ST_IDLE;
            ST_WRITE, ST_READ:            if (sdone && last_bit) state_nx = ST_IDLE;
            ST_TRIP_ID:                   if (sdone) state_nx = ST_TRIP_CMP;
            ST_TRIP_CMP:                  if (sdone) state_nx = ST_TRIP_WR;
            default:                      state_nx = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            launch      <= 1'b0;
            cur_bit     <= 1'b1;
            od_q        <= 1'b0;
            mask_q      <= 1'b0;
            dir_q       <= 1'b0;
            shreg       <= '0;
            bitcnt      <= '0;
            st_done     <= 1'b0;
            st_presence <= 1'b0;
            st_short    <= 1'b0;
            st_bit      <= 1'b0;
            st_bit2     <= 1'b0;
            st_dir      <= 1'b0;
            st_err      <= 1'b0;
            rd_data     <= '0;
        end else begin
            launch <= 1'b0;
            if (acc) begin
                st_done     <= 1'b0;
                st_presence <= 1'b0;
                st_short    <= 1'b0;
                st_bit      <= 1'b0;
                st_bit2     <= 1'b0;
                st_dir      <= 1'b0;
                st_err      <= 1'b0;
                od_q        <= cfg_overdrive;
                mask_q      <= cfg_mask_presence;
                dir_q       <= cmd_bit;
                shreg       <= cmd_data;
                bitcnt      <= '0;
                launch      <= 1'b1;
                if (cmd_op == OP_WRBYTE)   cur_bit <= cmd_data[0];
                else if (cmd_op == OP_BIT) cur_bit <= cmd_bit;
                else                       cur_bit <= 1'b1;
            end else if (sdone) begin
                unique case (state)
                    ST_RESET: begin
                        st_presence <= mask_q || !samp;
                        st_short    <= !samp && !endb;
                        st_done     <= 1'b1;
                    end
                    ST_WRITE: begin
                        if (last_bit) begin
                            st_done <= 1'b1;
                        end else begin
                            shreg   <= shreg >> 1;
                            cur_bit <= shreg[1];
                            bitcnt  <= bitcnt + 1'b1;
                            launch  <= 1'b1;
                        end
                    end
                    ST_READ: begin
                        shreg <= {samp, shreg[DATA_W-1:1]};
                        if (last_bit) begin
                            rd_data <= {samp, shreg[DATA_W-1:1]};
                            st_done <= 1'b1;
                        end else begin
                            bitcnt  <= bitcnt + 1'b1;
                            cur_bit <= 1'b1;
                            launch  <= 1'b1;
                        end
                    end
                    ST_BIT: begin
                        st_bit  <= samp;
                        st_done <= 1'b1;
                    end
                    ST_TRIP_ID: begin
                        st_bit  <= samp;
                        cur_bit <= 1'b1;
                        launch  <= 1'b1;
                    end
                    ST_TRIP_CMP: begin
                        st_bit2 <= samp;
                        st_dir  <= trip_dir;
                        st_err  <= st_bit && samp;
                        cur_bit <= trip_dir;
                        launch  <= 1'b1;
                    end
                    ST_TRIP_WR: st_done <= 1'b1;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/owm_seq_chk.sv
module owm_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic drive_low,
    input logic st_done,
    input logic st_presence,
    input logic st_short,
    input logic st_bit,
    input logic st_bit2,
    input logic st_dir,
    input logic st_err
);
    // R1 R2: the bus is only driven during an operation
    assert_drive_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> busy);

    // R2: completion flag and busy never coexist
    assert_done_excl_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_done && busy));

    // R2: end of an operation always raises completion
    assert_done_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> st_done);

    // R4: short implies presence
    assert_short_has_presence_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_short |-> st_presence);

    // R9: both-ones error means both bits and direction read 1
    assert_err_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_err |-> (st_dir && st_bit && st_bit2));

    // R10: status holds while idle without a command
    assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> $stable({st_done, st_presence, st_short, st_bit, st_bit2, st_dir, st_err}));
endmodule

bind owm_seq owm_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .busy        (busy),
    .drive_low   (drive_low),
    .st_done     (st_done),
    .st_presence (st_presence),
    .st_short    (st_short),
    .st_bit      (st_bit),
    .st_bit2     (st_bit2),
    .st_dir      (st_dir),
    .st_err      (st_err)
);

// File: tb/owm_seq_bench.sv
`timescale 1ns/1ps
module owm_seq_bench;
    localparam int U = 2;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       cmd_valid = 0;
    logic [2:0] cmd_op = 0;
    logic [7:0] cmd_data = 0;
    logic       cmd_bit = 0;
    logic       cfg_od = 0;
    logic       cfg_mask = 0;
    logic       line_in;
    logic       drive_low, busy, st_done, st_presence, st_short;
    logic       st_bit, st_bit2, st_dir, st_err;
    logic [7:0] rd_data;

    logic        slave_low = 0;
    logic        short_mode = 0;
    logic        present = 0;
    logic [31:0] rd_bits = '1;
    int          ridx = 0;
    int          nw = 0;
    int          nr = 0;
    int          rst_w = 0;
    bit          wlog [64];
    int          wwid [64];

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    assign line_in = !(drive_low || slave_low || short_mode);

    owm_seq #(.TICK_DIV(U), .DATA_W(8)) u_owm_seq (
        .clk               (clk),
        .rst_n             (rst_n),
        .cmd_valid         (cmd_valid),
        .cmd_op            (cmd_op),
        .cmd_data          (cmd_data),
        .cmd_bit           (cmd_bit),
        .cfg_overdrive     (cfg_od),
        .cfg_mask_presence (cfg_mask),
        .line_in           (line_in),
        .drive_low         (drive_low),
        .busy              (busy),
        .st_done           (st_done),
        .st_presence       (st_presence),
        .st_short          (st_short),
        .st_bit            (st_bit),
        .st_bit2           (st_bit2),
        .st_dir            (st_dir),
        .st_err            (st_err),
        .rd_data           (rd_data)
    );

    // Device model: measures each low pulse, answers reads and resets, logs bits
    initial begin
        int  t, w, rec_t, hold_t;
        bit  rec;
        forever begin
            @(negedge clk);
            if (drive_low) begin
                rec_t  = cfg_od ? 3 * U : 25 * U;
                hold_t = cfg_od ? 4 * U : 30 * U;
                slave_low = !rd_bits[ridx % 32];
                t = 0;
                rec = 1'b1;
                while (drive_low) begin
                    @(negedge clk);
                    t++;
                    if (t == rec_t) rec = line_in;
                end
                w = t;
                while (t < hold_t) begin
                    @(negedge clk);
                    t++;
                    if (t == rec_t) rec = line_in;
                end
                slave_low = 0;
                if (w > (cfg_od ? 20 : 200) * U) begin
                    nr++;
                    rst_w = w;
                    if (present) begin
                        repeat ((cfg_od ? 2 : 15) * U) @(negedge clk);
                        slave_low = 1;
                        repeat ((cfg_od ? 13 : 120) * U) @(negedge clk);
                        slave_low = 0;
                    end
                end else begin
                    wlog[nw % 64] = rec;
                    wwid[nw % 64] = w;
                    nw++;
                    ridx++;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_near(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act < exp - 1 || act > exp + 1) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [7:0] d, input logic b);
        @(negedge clk);
        ridx = 0;
        cmd_op = op;
        cmd_data = d;
        cmd_bit = b;
        cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int nw0, nr0;
        logic [7:0] v, got;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11", "busy", busy, 0);
        chk("R11", "drive_low", drive_low, 0);
        chk("R11", "flags", {st_done, st_presence, st_short, st_bit, st_bit2, st_dir, st_err}, 0);
        chk("R11", "rd_data", rd_data, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R3 reset normal speed with a device present
        present = 1;
        run(0, 0, 0);
        chk_near("R3", "reset low width normal", rst_w, 480 * U);
        chk("R3", "presence", st_presence, 1);
        chk("R4", "no short", st_short, 0);
        chk("R2", "done", st_done, 1);
        // R3 no device
        present = 0;
        run(0, 0, 0);
        chk("R3", "no presence", st_presence, 0);
        // R5 masking
        cfg_mask = 1;
        run(0, 0, 0);
        chk("R5", "masked presence", st_presence, 1);
        cfg_mask = 0;
        // R4 short
        short_mode = 1;
        run(0, 0, 0);
        chk("R4", "short", st_short, 1);
        chk("R4", "presence with short", st_presence, 1);
        short_mode = 0;
        // R3 overdrive reset
        cfg_od = 1;
        present = 1;
        run(0, 0, 0);
        chk_near("R3", "reset low width overdrive", rst_w, 48 * U);
        chk("R3", "presence overdrive", st_presence, 1);
        // R10 flags cleared by next command
        rd_bits = '1;
        run(1, 8'h5A, 0);
        chk("R10", "presence cleared", st_presence, 0);
        present = 0;

        // R6 slot widths
        cfg_od = 0;
        nw0 = nw;
        run(1, 8'h01, 0);
        chk_near("R6", "write1 low normal", wwid[nw0 % 64], 6 * U);
        chk_near("R6", "write0 low normal", wwid[(nw0 + 1) % 64], 60 * U);
        cfg_od = 1;
        nw0 = nw;
        run(1, 8'h02, 0);
        chk_near("R6", "write0 low overdrive", wwid[nw0 % 64], 8 * U);
        chk_near("R6", "write1 low overdrive", wwid[(nw0 + 1) % 64], 1 * U);

        // R6 write sweep, overdrive
        for (int i = 0; i < 256; i += 5) begin
            v = 8'(i);
            nw0 = nw;
            run(1, v, 0);
            got = '0;
            for (int k = 0; k < 8; k++) got[k] = wlog[(nw0 + k) % 64];
            chk("R6", "written byte LSB first", got, v);
            chk("R6", "slot count", nw - nw0, 8);
        end
        // R6 normal speed write
        cfg_od = 0;
        nw0 = nw;
        run(1, 8'hC5, 0);
        got = '0;
        for (int k = 0; k < 8; k++) got[k] = wlog[(nw0 + k) % 64];
        chk("R6", "written byte normal", got, 8'hC5);

        // R7 read sweep, overdrive, all values
        cfg_od = 1;
        for (int i = 0; i < 256; i++) begin
            rd_bits = {24'hFFFFFF, 8'(i)};
            run(2, 0, 0);
            chk("R7", "read byte", rd_data, i);
        end
        // R7 normal speed read
        cfg_od = 0;
        rd_bits = {24'hFFFFFF, 8'h3C};
        run(2, 0, 0);
        chk("R7", "read byte normal", rd_data, 8'h3C);
        // R10 rd_data kept across other commands
        run(3, 0, 1);
        chk("R10", "rd_data kept", rd_data, 8'h3C);

        // R8 single bit
        rd_bits = 32'hFFFF_FFFE;
        run(3, 0, 1);
        chk("R8", "write1 device0", st_bit, 0);
        rd_bits = '1;
        run(3, 0, 1);
        chk("R8", "write1 device1", st_bit, 1);
        nw0 = nw;
        run(3, 0, 0);
        chk("R8", "write0 reads 0", st_bit, 0);
        chk("R8", "write0 heard", wlog[nw0 % 64], 0);

        // R9 search step, all bit pairs and both preferred directions, both speeds
        for (int sp = 0; sp < 2; sp++) begin
            cfg_od = sp[0];
            for (int c = 0; c < 8; c++) begin
                logic id, cm, dn, ed;
                id = c[0];
                cm = c[1];
                dn = (!id && !cm) ? c[2] : id;
                ed = id && cm;
                rd_bits = {29'h1FFFFFFF, 1'b1, cm, id};
                nw0 = nw;
                run(4, 0, c[2]);
                chk("R9", "id bit", st_bit, id);
                chk("R9", "complement bit", st_bit2, cm);
                chk("R9", "direction", st_dir, dn);
                chk("R9", "error", st_err, ed);
                chk("R9", "direction written", wlog[(nw0 + 2) % 64], dn);
            end
        end

        // R1 undefined op codes ignored
        for (int op = 5; op < 8; op++) begin
            nw0 = nw;
            nr0 = nr;
            @(negedge clk);
            cmd_op = 3'(op);
            cmd_valid = 1;
            @(negedge clk);
            cmd_valid = 0;
            chk("R1", "busy after bad op", busy, 0);
            repeat (40) @(negedge clk);
            chk("R1", "no slots after bad op", (nw - nw0) + (nr - nr0), 0);
        end

        // R2 command while busy ignored
        cfg_od = 0;
        rd_bits = '1;
        nw0 = nw;
        nr0 = nr;
        @(negedge clk);
        ridx = 0;
        cmd_op = 2;
        cmd_valid = 1;
        @(negedge clk);
        cmd_op = 0;
        repeat (20) @(negedge clk);
        chk("R2", "busy during op", busy, 1);
        cmd_valid = 0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R2", "read ran to end", rd_data, 8'hFF);
        chk("R2", "no reset while busy", nr - nr0, 0);
        chk("R2", "slot count", nw - nw0, 8);

        summary();
    end
endmodule